// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits on a simple 32-bit register bus and stands in for a one-time-programmable fuse macro. The macro holds `WORDS` words of 32 bits. Software reaches the macro's control pins through a set of register words: word index, bit select, redundancy select, chip enable, clock, data in, data strobe, program, trim, write enable and four test registers. It reads whole fuse words through a read-only data port and programs one bit at a time.

Programming fires on a write to the write-enable register. A per-bit written map refuses a second program of any bit and raises a sticky error flag. After reset an internal sweep fills the array. Every word becomes all ones, except that a serial-number parameter goes at a fixed word index and its bitwise complement goes at the next index. The sweep also clears the written map.

Register byte offsets: 0x00 word index, 0x04 bit select, 0x08 redundancy select, 0x0C chip enable, 0x10 clock, 0x14 data in, 0x18 data out, 0x1C strobe, 0x20 program, 0x24 test control, 0x28 test mode, 0x2C test repair, 0x30 test read, 0x34 trim, 0x38 write enable, 0x3C status.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, `init_busy` is high while the array is swept, and bus requests are ignored: no response and no state change. Once `init_busy` falls it stays low. From then on every word reads 0xFFFFFFFF, except that word `SERIAL_IDX` reads `SERIAL` and word `SERIAL_IDX`+1 reads `~SERIAL`. No bit is marked written.
- R2: A read of data out (0x18) returns the word at the current word index when bit 0 of chip enable (0x0C), bit 0 of strobe (0x1C) and bit 0 of trim (0x34) are all 1. Otherwise it returns 0x000000FF.
- R3: A write to the word index (0x00) keeps only the low log2(`WORDS`) bits (12 bits by default), and reads back masked.
- R4: Data out is read-only. A write to it changes nothing.
- R5: A write to write enable (0x38) keeps only bit 0. When that bit is 1 and redundancy select (0x08) is zero, bit `bitsel[4:0]` of the indexed word takes the value of data in (0x14) bit 0. The change is visible on the very next read of data out.
- R6: While redundancy select is nonzero, a write-enable write programs nothing and marks no bit written.
- R7: A program attempt on a bit already programmed is refused. The word stays unchanged and status (0x3C) bit 0 is set.
- R8: Status bit 0 is sticky. It clears only on a write to status with bit 0 = 1. All other status bits read 0.
- R9: All other registers reset to 0 and read back the last value written.
- R10: A read of an unmapped offset (0x40 and above) or a misaligned offset (low two bits nonzero) returns 0. A write to one changes nothing. Either access pulses `bus_err` with the response.
- R11: A read gets its data with `bus_rvalid` in the cycle after the request. A write produces no `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read response valid |
| bus_err | output | 1 | Bad-offset response pulse |
| init_busy | output | 1 | Post-reset array sweep in progress |

## Verification
The hardest state to reach is a refused program. To get there, the same word index and bit select must be kept while a second write-enable write arrives with the redundancy select back at zero. A redundancy-blocked attempt in between must not have marked the bit. The random phase therefore draws word indices from a small pool that includes the serial words and the two array ends. It also draws bit selects from 32 values and biases redundancy select toward zero. This makes repeated hits on one bit common. Directed steps then force the refuse, the sticky clear and the redundancy-blocked case in a fixed order.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int REG_COUNT = 16;
  localparam int REG_IDX_W = 4;
  localparam int DATA_W    = 32;
  localparam int BIT_SEL_W = $clog2(DATA_W);

  typedef enum logic [REG_IDX_W-1:0] {
    REG_ADDR   = 4'd0,
    REG_BITSEL = 4'd1,
    REG_REDSEL = 4'd2,
    REG_CE     = 4'd3,
    REG_CLK    = 4'd4,
    REG_DIN    = 4'd5,
    REG_DOUT   = 4'd6,
    REG_STROBE = 4'd7,
    REG_PROG   = 4'd8,
    REG_TCTL   = 4'd9,
    REG_TMODE  = 4'd10,
    REG_TREP   = 4'd11,
    REG_TREAD  = 4'd12,
    REG_TRIM   = 4'd13,
    REG_WREN   = 4'd14,
    REG_STATUS = 4'd15
  } reg_idx_e;

  localparam logic [DATA_W-1:0] DOUT_BLOCKED = 32'h0000_00FF;
endpackage

// File: rtl/otp_regfile.sv
module otp_regfile
  import otp_pkg::*;
#(
  parameter int AW = 12
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_en,
  input  logic [REG_IDX_W-1:0]             wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             err_set,
  output logic [REG_COUNT-1:0][DATA_W-1:0] regs,
  output logic [AW-1:0]                    pa_nxt
);
  localparam logic [DATA_W-1:0] ADDR_KEEP = {{(DATA_W-AW){1'b0}}, {AW{1'b1}}};

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    if (g == int'(REG_DOUT)) begin : g_ro
      assign regs[g] = '0;
    end else if (g == int'(REG_STATUS)) begin : g_sts
      logic flag_q;
      always_ff @(posedge clk) begin
        if (rst)
          flag_q <= 1'b0;
        else if (err_set)
          flag_q <= 1'b1;
        else if (wr_en && wr_idx == REG_IDX_W'(g) && wr_data[0])
          flag_q <= 1'b0;
      end
      assign regs[g] = {{(DATA_W-1){1'b0}}, flag_q};
    end else begin : g_rw
      localparam logic [DATA_W-1:0] KEEP =
        (g == int'(REG_ADDR)) ? ADDR_KEEP :
        (g == int'(REG_WREN)) ? 32'h1 : '1;
      logic [DATA_W-1:0] val_q;
      always_ff @(posedge clk) begin
        if (rst)
          val_q <= '0;
        else if (wr_en && wr_idx == REG_IDX_W'(g))
          val_q <= wr_data & KEEP;
      end
      assign regs[g] = val_q;
    end
  end

  assign pa_nxt = (wr_en && wr_idx == REG_ADDR) ? wr_data[AW-1:0]
                                                : regs[REG_ADDR][AW-1:0];
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array #(
  parameter int          WORDS      = 4096,
  parameter int          AW         = 12,
  parameter int          W          = 32,
  parameter logic [31:0] SERIAL     = 32'h5EED_0001,
  parameter int          SERIAL_IDX = 252
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_addr,
  input  logic          upd_en,
  input  logic [AW-1:0] upd_addr,
  input  logic [W-1:0]  upd_fuse,
  input  logic [W-1:0]  upd_map,
  output logic [W-1:0]  rd_fuse,
  output logic [W-1:0]  rd_map,
  output logic          busy
);
  logic [W-1:0]  fuse_mem [WORDS];
  logic [W-1:0]  map_mem  [WORDS];
  logic [AW-1:0] sweep_q;
  logic          busy_q;
  logic          we;
  logic [AW-1:0] wa;
  logic [W-1:0]  wf, wm, seed_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q  <= 1'b1;
      sweep_q <= '0;
    end else if (busy_q) begin
      sweep_q <= sweep_q + 1'b1;
      if (sweep_q == AW'(WORDS - 1))
        busy_q <= 1'b0;
    end
  end

  always_comb begin
    if (sweep_q == AW'(SERIAL_IDX))
      seed_word = W'(SERIAL);
    else if (sweep_q == AW'(SERIAL_IDX + 1))
      seed_word = ~W'(SERIAL);
    else
      seed_word = '1;
  end

  assign we = !rst && (busy_q || upd_en);
  assign wa = busy_q ? sweep_q   : upd_addr;
  assign wf = busy_q ? seed_word : upd_fuse;
  assign wm = busy_q ? '0        : upd_map;

  always_ff @(posedge clk) begin
    if (we) begin
      fuse_mem[wa] <= wf;
      map_mem[wa]  <= wm;
    end
    rd_fuse <= (we && wa == rd_addr) ? wf : fuse_mem[rd_addr];
    rd_map  <= (we && wa == rd_addr) ? wm : map_mem[rd_addr];
  end

  assign busy = busy_q;
endmodule

// File: rtl/otp_bit_prog.sv
module otp_bit_prog #(
  parameter int W  = 32,
  parameter int BW = 5
) (
  input  logic          fire,
  input  logic [BW-1:0] bit_sel,
  input  logic          din,
  input  logic [W-1:0]  cur_fuse,
  input  logic [W-1:0]  cur_map,
  output logic          commit,
  output logic          refuse,
  output logic [W-1:0]  nxt_fuse,
  output logic [W-1:0]  nxt_map
);
  logic [W-1:0] onehot;
  logic         taken;

  assign onehot   = W'(1) << bit_sel;
  assign taken    = cur_map[bit_sel];
  assign commit   = fire && !taken;
  assign refuse   = fire && taken;
  assign nxt_fuse = din ? (cur_fuse | onehot) : (cur_fuse & ~onehot);
  assign nxt_map  = cur_map | onehot;
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_pkg::*;
#(
  parameter int          WORDS      = 4096,
  parameter int          ADDR_W     = 8,
  parameter logic [31:0] SERIAL     = 32'h5EED_0001,
  parameter int          SERIAL_IDX = 252
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic              bus_err,
  output logic              init_busy
);
  localparam int AW = $clog2(WORDS);

  logic                             req, mapped, wr_en, fire, gate_ok;
  logic [REG_IDX_W-1:0]             idx;
  logic [REG_COUNT-1:0][DATA_W-1:0] regs;
  logic [AW-1:0]                    pa_nxt, pa_q;
  logic [DATA_W-1:0]                cur_fuse, cur_map, nxt_fuse, nxt_map, rd_val;
  logic                             prog_we, prog_refuse, wo_err;

  assign req     = bus_valid && !init_busy;
  assign idx     = bus_addr[REG_IDX_W+1:2];
  assign mapped  = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:REG_IDX_W+2] == '0);
  assign wr_en   = req && bus_write && mapped;
  assign fire    = wr_en && idx == REG_WREN && bus_wdata[0] && regs[REG_REDSEL] == '0;
  assign gate_ok = regs[REG_CE][0] && regs[REG_STROBE][0] && regs[REG_TRIM][0];
  assign pa_q    = regs[REG_ADDR][AW-1:0];
  assign wo_err  = regs[REG_STATUS][0];

  otp_regfile #(.AW(AW)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (idx),
    .wr_data (bus_wdata),
    .err_set (prog_refuse),
    .regs    (regs),
    .pa_nxt  (pa_nxt)
  );

  otp_fuse_array #(
    .WORDS(WORDS), .AW(AW), .W(DATA_W), .SERIAL(SERIAL), .SERIAL_IDX(SERIAL_IDX)
  ) u_array (
    .clk      (clk),
    .rst      (rst),
    .rd_addr  (pa_nxt),
    .upd_en   (prog_we),
    .upd_addr (pa_q),
    .upd_fuse (nxt_fuse),
    .upd_map  (nxt_map),
    .rd_fuse  (cur_fuse),
    .rd_map   (cur_map),
    .busy     (init_busy)
  );

  otp_bit_prog #(.W(DATA_W), .BW(BIT_SEL_W)) u_prog (
    .fire     (fire),
    .bit_sel  (regs[REG_BITSEL][BIT_SEL_W-1:0]),
    .din      (regs[REG_DIN][0]),
    .cur_fuse (cur_fuse),
    .cur_map  (cur_map),
    .commit   (prog_we),
    .refuse   (prog_refuse),
    .nxt_fuse (nxt_fuse),
    .nxt_map  (nxt_map)
  );

  always_comb begin
    rd_val = regs[idx];
    if (idx == REG_DOUT)
      rd_val = gate_ok ? cur_fuse : DOUT_BLOCKED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      bus_err    <= 1'b0;
    end else begin
      bus_rvalid <= req && !bus_write;
      bus_err    <= req && !mapped;
      bus_rdata  <= (req && !bus_write && mapped) ? rd_val : '0;
    end
  end
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              bus_rvalid,
  input logic              bus_err,
  input logic              init_busy,
  input logic              gate_ok,
  input logic              wo_err,
  input logic              prog_we
);
  // R11
  rvalid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid |-> $past(bus_valid && !bus_write && !init_busy));

  // R10
  err_after_req_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_valid && !init_busy));

  // R1
  init_once_chk: assert property (@(posedge clk) disable iff (rst)
    !init_busy |=> !init_busy);

  // R1
  no_prog_in_init_chk: assert property (@(posedge clk) disable iff (rst)
    init_busy |-> !prog_we);

  // R7
  wo_err_source_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wo_err) |-> $past(bus_valid && bus_write && !init_busy));

  // R2
  gated_ff_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bus_valid && !bus_write && !init_busy && bus_addr == ADDR_W'(24) && !gate_ok)
      |-> bus_rdata == 32'h0000_00FF);
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_valid  (bus_valid),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .bus_err    (bus_err),
  .init_busy  (init_busy),
  .gate_ok    (gate_ok),
  .wo_err     (wo_err),
  .prog_we    (prog_we)
);

// File: tb/otp_fuse_ctrl_tb.sv
module otp_fuse_ctrl_tb;
  localparam int          WORDS  = 4096;
  localparam int          SIDX   = 252;
  localparam logic [31:0] SERIAL = 32'h5EED_0001;
  localparam logic [31:0] AMASK  = 32'h0000_0FFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid, bus_err, init_busy;

  int checks = 0, fails = 0;
  logic [31:0] m_fuse [WORDS];
  logic [31:0] m_map  [WORDS];
  logic [31:0] m_regs [16];
  logic        m_sts;
  logic [31:0] g_data;
  logic        g_err, g_rv;

  always #2.5 clk = ~clk;

  otp_fuse_ctrl #(.WORDS(WORDS), .ADDR_W(8), .SERIAL(SERIAL), .SERIAL_IDX(SIDX)) u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .bus_err(bus_err), .init_busy(init_busy)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  function automatic void model_reset();
    for (int i = 0; i < WORDS; i++) begin
      m_fuse[i] = '1;
      m_map[i]  = '0;
    end
    m_fuse[SIDX]     = SERIAL;
    m_fuse[SIDX + 1] = ~SERIAL;
    for (int i = 0; i < 16; i++) m_regs[i] = '0;
    m_sts = 1'b0;
  endfunction

  function automatic logic [31:0] model_read(input int idx);
    int pa;
    pa = int'(m_regs[0] & AMASK);
    if (idx == 6)
      return (m_regs[3][0] && m_regs[7][0] && m_regs[13][0]) ? m_fuse[pa] : 32'hFF;
    if (idx == 15) return {31'b0, m_sts};
    return m_regs[idx];
  endfunction

  function automatic void model_write(input int idx, input logic [31:0] d);
    int pa, b;
    case (idx)
      0:  m_regs[0] = d & AMASK;
      6:  ;
      15: if (d[0]) m_sts = 1'b0;
      14: begin
        m_regs[14] = d & 32'h1;
        if (d[0] && m_regs[2] == 0) begin
          pa = int'(m_regs[0] & AMASK);
          b  = int'(m_regs[1][4:0]);
          if (m_map[pa][b]) m_sts = 1'b1;
          else begin
            m_fuse[pa][b] = m_regs[5][0];
            m_map[pa][b]  = 1'b1;
          end
        end
      end
      default: m_regs[idx] = d;
    endcase
  endfunction

  task automatic raw(input logic wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0;
    g_data = bus_rdata; g_err = bus_err; g_rv = bus_rvalid;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    raw(1'b1, 8'(idx * 4), d);
    model_write(idx, d);
    check("R11 write no rvalid", {31'b0, g_rv}, 32'd0);
    check("R10 mapped write no err", {31'b0, g_err}, 32'd0);
  endtask

  task automatic rd(input int idx, input string req);
    raw(1'b0, 8'(idx * 4), '0);
    check("R11 read rvalid", {31'b0, g_rv}, 32'd1);
    check(req, g_data, model_read(idx));
  endtask

  task automatic do_reset();
    int n;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    @(negedge clk);
    check("R1 busy after reset", {31'b0, init_busy}, 32'd1);
    raw(1'b1, 8'h00, 32'h5);
    raw(1'b0, 8'h00, '0);
    check("R1 no response during sweep", {31'b0, g_rv}, 32'd0);
    n = 0;
    while (init_busy && n < WORDS + 16) begin
      @(negedge clk); n++;
    end
    check("R1 sweep ends", {31'b0, init_busy}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    for (int i = 0; i < 16; i++) rd(i, "R9 reset value / R2 gated");
    rd(0, "R1 write during sweep ignored");

    wr(3, 1); wr(7, 1); wr(13, 1);
    wr(0, SIDX);     rd(6, "R1 serial word");
    wr(0, SIDX + 1); rd(6, "R1 serial complement");
    wr(0, 7);        rd(6, "R1 blank word");
    wr(0, WORDS - 1); rd(6, "R1 last word");

    wr(0, 32'hFFFF_F123); rd(0, "R3 index masked");
    check("R3 explicit", m_regs[0], 32'h123);

    wr(6, 32'h0); rd(6, "R4 dout write dropped");

    wr(0, 3); wr(1, 9); wr(5, 0);
    wr(14, 32'hFFFF_FFFE); rd(14, "R5 only bit0 kept"); rd(6, "R5 no program on bit0=0");
    wr(14, 32'h1); rd(6, "R5 program clears bit");
    check("R5 explicit", model_read(6), 32'hFFFF_FDFF);
    rd(14, "R5 wren readback");

    wr(5, 1); wr(14, 1);
    rd(6, "R7 refused word unchanged"); rd(15, "R7 status set");
    wr(15, 0); rd(15, "R8 sticky on write 0");
    wr(15, 32'hFFFF_FFFF); rd(15, "R8 cleared by write 1");

    wr(2, 1); wr(1, 10); wr(5, 0); wr(14, 1);
    rd(6, "R6 redundancy blocks program"); rd(15, "R6 no error");
    wr(2, 0); wr(14, 1);
    rd(6, "R6 bit still programmable"); rd(15, "R6 status clear");

    wr(3, 0); rd(6, "R2 chip enable off");
    wr(3, 1); wr(7, 0); rd(6, "R2 strobe off");
    wr(7, 1); wr(13, 0); rd(6, "R2 trim off");
    wr(13, 1); rd(6, "R2 all on");

    foreach (bus_addr[k]) begin end
    raw(1'b0, 8'h40, '0);
    check("R10 unmapped read data", g_data, 32'h0);
    check("R10 unmapped read err", {31'b0, g_err}, 32'd1);
    raw(1'b0, 8'h05, '0);
    check("R10 misaligned read data", g_data, 32'h0);
    check("R10 misaligned read err", {31'b0, g_err}, 32'd1);
    raw(1'b1, 8'h44, 32'h1F);
    check("R10 unmapped write err", {31'b0, g_err}, 32'd1);
    rd(1, "R10 unmapped write no effect");
    raw(1'b1, 8'h01, 32'h1F);
    rd(0, "R10 misaligned write no effect");

    for (int i = 0; i < 16; i++) begin
      if (i != 0 && i != 6 && i != 14 && i != 15) begin
        if (i == 2 || i == 3 || i == 7 || i == 13) continue;
        wr(i, $urandom);
        rd(i, "R9 holding register");
      end
    end

    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom % 9);
      case (op)
        0: begin
          int sel;
          sel = int'($urandom % 5);
          wr(0, sel == 0 ? SIDX : sel == 1 ? SIDX + 1 : sel == 2 ? 0 :
                sel == 3 ? WORDS - 1 : ($urandom % 8));
        end
        1: wr(1, ($urandom % 4 == 0) ? $urandom : ($urandom % 32));
        2: wr(5, $urandom);
        3: wr(2, ($urandom % 6 == 0) ? ($urandom | 32'h100) : 0);
        4, 5: wr(14, $urandom);
        6: rd(6, "R5 random dout");
        7: begin
          rd(15, "R7 random status");
          if ($urandom % 3 == 0) wr(15, 1);
        end
        default: begin
          int en;
          en = int'($urandom % 3);
          wr(en == 0 ? 3 : en == 1 ? 7 : 13, ($urandom % 5 == 0) ? 0 : 1);
        end
      endcase
    end

    wr(3, 1); wr(7, 1); wr(13, 1); wr(0, 3);
    do_reset();
    wr(3, 1); wr(7, 1); wr(13, 1); wr(0, 3);
    rd(6, "R1 reset restores blank");
    rd(15, "R1 status cleared by reset");
    wr(1, 9); wr(5, 0); wr(14, 1);
    rd(6, "R1 written map cleared");
    rd(15, "R1 no refuse after reset");

    summary();
    $finish;
  end
endmodule